// File: doc/BRIEF.md
# Paired Byte Register File

This block holds the six general byte registers of a small 8-bit datapath, named B, C, D, E, H and L, together with a 16-bit stack pointer. Any byte register can be read or written on its own. The registers can also be handled as three 16-bit pairs, BC, DE and HL. In each pair the first register is the high byte.

The block does three kinds of whole-pair work:

- It loads a 16-bit immediate value into BC, DE, HL or SP.
- It steps one of those pairs up or down by one. The step reports no flags and wraps around.
- It swaps DE with HL in a single cycle.

HL is driven out at all times, so the surrounding datapath can use it as the address for operations on a memory operand. Reads are combinational. All writes take effect on the next rising clock edge.

A decoder outside the block drives the byte select codes, the pair select and the pair operation code. The accumulator is not held here, and neither is the memory operand. The two select codes that name them are handled as described in R2 and R8.

Top module: `pairreg_file`

## Requirements
- R1: With `wr_en` high and no pair operation, a byte select of B=000, C=001, D=010, E=011, H=100 or L=101 loads `wr_data` into that register at the next rising edge, and no other register changes.
- R2: The two byte read ports return the selected register combinationally using the R1 codes. Select 110 (memory operand) and select 111 (accumulator) both read as zero.
- R3: The pair select codes are 00=BC, 01=DE, 10=HL and 11=SP, with B, D and H as the high bytes. `pair_rd_data` returns {high, low} of the pair chosen by `pair_rd_sel`, combinationally.
- R4: Pair operation 001 loads `pair_imm` into the pair chosen by `pair_sel` at the next edge.
- R5: Pair operation 010 adds one to the selected pair and 011 subtracts one, both modulo 2^16. No other register changes.
- R6: Pair operation 100 swaps DE and HL in one cycle, whatever the value of `pair_sel`. BC and SP are unchanged.
- R7: When pair operation 001 to 100 is active, a byte write in the same cycle is discarded.
- R8: A byte write with select 110 or 111 changes no register.
- R9: `hl_addr` always equals {H, L}.
- R10: While `rst_n` is low, all six byte registers and SP are cleared to zero. This reset is asynchronous.
- R11: Pair operation codes 101, 110 and 111 act as no operation, so a byte write in the same cycle takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_a | input | 3 | Byte select for read port A |
| rd_data_a | output | BYTE_W | Read port A data |
| rd_sel_b | input | 3 | Byte select for read port B |
| rd_data_b | output | BYTE_W | Read port B data |
| wr_en | input | 1 | Byte write enable |
| wr_sel | input | 3 | Byte write select |
| wr_data | input | BYTE_W | Byte write data |
| pair_op | input | 3 | Pair operation code |
| pair_sel | input | 2 | Pair targeted by the pair operation |
| pair_imm | input | 2*BYTE_W | Immediate value for a pair load |
| pair_rd_sel | input | 2 | Pair read select |
| pair_rd_data | output | 2*BYTE_W | Pair read data |
| hl_addr | output | 2*BYTE_W | HL pair, used as the memory address |

## Verification
The bench runs directed and random patterns.

- **Wrap boundaries.** HL and SP are stepped up from FFFF and DE is stepped down from 0000. This separates a true 16-bit carry or borrow from an 8-bit one that stays inside the low byte.
- **Byte order.** Pairs are loaded and then read back byte by byte. This exposes high/low byte swaps and pair-select decode errors.
- **Exchange.** The swap is run with a misleading `pair_sel`, to show that the select is ignored.
- **Conflicting requests.** A pair operation and a byte write are driven in the same cycle. Reserved opcodes and the 110/111 byte selects are also driven. Together these tell the priority rule apart from a merge of the two writes.
- **Random phase.** Long random sequences are compared every cycle with a behavioural model.

// File: rtl/pairreg_pkg.sv
package pairreg_pkg;

   typedef enum logic [2:0] {
      POP_NONE = 3'd0,
      POP_LOAD = 3'd1,
      POP_INC  = 3'd2,
      POP_DEC  = 3'd3,
      POP_XCHG = 3'd4
   } pair_op_e;

   localparam int unsigned NUM_BYTES = 6;
   localparam int unsigned NUM_PAIRS = 3;
   localparam int unsigned RD_PORTS  = 2;

   localparam int unsigned IDX_B = 0;
   localparam int unsigned IDX_C = 1;
   localparam int unsigned IDX_D = 2;
   localparam int unsigned IDX_E = 3;
   localparam int unsigned IDX_H = 4;
   localparam int unsigned IDX_L = 5;

   localparam logic [1:0] PSEL_BC = 2'b00;
   localparam logic [1:0] PSEL_DE = 2'b01;
   localparam logic [1:0] PSEL_HL = 2'b10;
   localparam logic [1:0] PSEL_SP = 2'b11;

endpackage

// File: rtl/pairreg_rdmux.sv
module pairreg_rdmux #(
   parameter int unsigned BW = 8,
   parameter int unsigned NB = 6
) (
   input  logic [2:0]            sel,
   input  logic [NB-1:0][BW-1:0] regs,
   output logic [BW-1:0]         data
);

   generate
      if (NB > 8) begin : g_bad_nb
         $error("pairreg_rdmux: NB must fit a 3-bit select");
      end
   endgenerate

   always_comb begin
      data = '0;
      for (int i = 0; i < int'(NB); i++) begin
         if (int'(sel) == i) data = regs[i];
      end
   end

endmodule

// File: rtl/pairreg_step.sv
module pairreg_step #(
   parameter int unsigned W      = 16,
   parameter bit          SHARED = 1'b1
) (
   input  logic [W-1:0] val,
   input  logic         down,
   output logic [W-1:0] res
);

   generate
      if (W < 2) begin : g_bad_w
         $error("pairreg_step: W must be at least 2");
      end
      if (SHARED) begin : g_shared
         // one adder; the addend is +1 or all ones (-1)
         logic [W-1:0] addend;
         assign addend = down ? {W{1'b1}} : {{(W-1){1'b0}}, 1'b1};
         assign res    = val + addend;
      end else begin : g_split
         logic [W-1:0] up_v;
         logic [W-1:0] dn_v;
         assign up_v = val + {{(W-1){1'b0}}, 1'b1};
         assign dn_v = val - {{(W-1){1'b0}}, 1'b1};
         assign res  = down ? dn_v : up_v;
      end
   endgenerate

endmodule

// File: rtl/pairreg_bank.sv
module pairreg_bank #(
   parameter int unsigned BW = 8,
   parameter int unsigned NB = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NB-1:0]         byte_we,
   input  logic [NB-1:0][BW-1:0] byte_din,
   input  logic                  sp_we,
   input  logic [2*BW-1:0]       sp_din,
   output logic [NB-1:0][BW-1:0] regs,
   output logic [2*BW-1:0]       sp
);

   genvar g;
   generate
      for (g = 0; g < int'(NB); g++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          regs[g] <= '0;
            else if (byte_we[g]) regs[g] <= byte_din[g];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sp <= '0;
      else if (sp_we) sp <= sp_din;
   end

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) // R1
      (byte_we == '0 && !sp_we) |=> (regs == $past(regs) && sp == $past(sp)));

endmodule

// File: rtl/pairreg_file.sv
module pairreg_file
   import pairreg_pkg::*;
#(
   parameter int unsigned BYTE_W     = 8,
   parameter bit          SHARED_ADD = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2:0]            rd_sel_a,
   output logic [BYTE_W-1:0]     rd_data_a,
   input  logic [2:0]            rd_sel_b,
   output logic [BYTE_W-1:0]     rd_data_b,
   input  logic                  wr_en,
   input  logic [2:0]            wr_sel,
   input  logic [BYTE_W-1:0]     wr_data,
   input  logic [2:0]            pair_op,
   input  logic [1:0]            pair_sel,
   input  logic [2*BYTE_W-1:0]   pair_imm,
   input  logic [1:0]            pair_rd_sel,
   output logic [2*BYTE_W-1:0]   pair_rd_data,
   output logic [2*BYTE_W-1:0]   hl_addr
);

   localparam int unsigned PAIR_W = 2 * BYTE_W;
   localparam int unsigned NB     = NUM_BYTES;

   generate
      if (BYTE_W < 1) begin : g_bad_bw
         $error("pairreg_file: BYTE_W must be positive");
      end
   endgenerate

   logic [NB-1:0][BYTE_W-1:0] regs;
   logic [PAIR_W-1:0]         sp;
   logic [NB-1:0]             byte_we;
   logic [NB-1:0][BYTE_W-1:0] byte_din;
   logic                      sp_we;
   logic [PAIR_W-1:0]         new_pair;
   logic [PAIR_W-1:0]         cur_pair;
   logic [PAIR_W-1:0]         stepped;
   logic [3:0][PAIR_W-1:0]    pair_view;
   pair_op_e                  op;

   assign op = pair_op_e'(pair_op);

   // 16-bit views of the byte registers; slot 3 is the stack pointer
   genvar p;
   generate
      for (p = 0; p < int'(NUM_PAIRS); p++) begin : g_pair
         assign pair_view[p] = {regs[2*p], regs[2*p+1]};
      end
   endgenerate
   assign pair_view[3] = sp;

   assign cur_pair     = pair_view[pair_sel];
   assign pair_rd_data = pair_view[pair_rd_sel];
   assign hl_addr      = pair_view[PSEL_HL];

   pairreg_step #(.W(PAIR_W), .SHARED(SHARED_ADD)) u_step (
      .val  (cur_pair),
      .down (op == POP_DEC),
      .res  (stepped)
   );

   assign new_pair = (op == POP_LOAD) ? pair_imm : stepped;

   always_comb begin
      byte_we  = '0;
      byte_din = regs;
      sp_we    = 1'b0;
      case (op)
         POP_LOAD, POP_INC, POP_DEC: begin
            if (pair_sel == PSEL_SP) begin
               sp_we = 1'b1;
            end else begin
               for (int i = 0; i < int'(NUM_PAIRS); i++) begin
                  if (int'(pair_sel) == i) begin
                     byte_we[2*i]    = 1'b1;
                     byte_we[2*i+1]  = 1'b1;
                     byte_din[2*i]   = new_pair[PAIR_W-1:BYTE_W];
                     byte_din[2*i+1] = new_pair[BYTE_W-1:0];
                  end
               end
            end
         end
         POP_XCHG: begin
            byte_we[IDX_D]  = 1'b1;
            byte_we[IDX_E]  = 1'b1;
            byte_we[IDX_H]  = 1'b1;
            byte_we[IDX_L]  = 1'b1;
            byte_din[IDX_D] = regs[IDX_H];
            byte_din[IDX_E] = regs[IDX_L];
            byte_din[IDX_H] = regs[IDX_D];
            byte_din[IDX_L] = regs[IDX_E];
         end
         default: begin
            for (int i = 0; i < int'(NB); i++) begin
               if (wr_en && int'(wr_sel) == i) begin
                  byte_we[i]  = 1'b1;
                  byte_din[i] = wr_data;
               end
            end
         end
      endcase
   end

   pairreg_bank #(.BW(BYTE_W), .NB(NB)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_we  (byte_we),
      .byte_din (byte_din),
      .sp_we    (sp_we),
      .sp_din   (new_pair),
      .regs     (regs),
      .sp       (sp)
   );

   logic [RD_PORTS-1:0][2:0]        rsel;
   logic [RD_PORTS-1:0][BYTE_W-1:0] rdat;
   assign rsel[0]   = rd_sel_a;
   assign rsel[1]   = rd_sel_b;
   assign rd_data_a = rdat[0];
   assign rd_data_b = rdat[1];

   genvar r;
   generate
      for (r = 0; r < int'(RD_PORTS); r++) begin : g_rd
         pairreg_rdmux #(.BW(BYTE_W), .NB(NB)) u_rdmux (
            .sel  (rsel[r]),
            .regs (regs),
            .data (rdat[r])
         );
      end
   endgenerate

   AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n) // R4
      (op == POP_LOAD) |=> (pair_view[$past(pair_sel)] == $past(pair_imm)));

   AST_INC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n) // R5
      (op == POP_INC) |=> (pair_view[$past(pair_sel)] == PAIR_W'($past(cur_pair) + 1'b1)));

   AST_XCHG_SWAPS: assert property (@(posedge clk) disable iff (!rst_n) // R6
      (op == POP_XCHG) |=> (pair_view[PSEL_HL] == $past(pair_view[PSEL_DE]) &&
                            pair_view[PSEL_DE] == $past(pair_view[PSEL_HL]) &&
                            pair_view[PSEL_BC] == $past(pair_view[PSEL_BC])));

   AST_PAIR_WINS: assert property (@(posedge clk) disable iff (!rst_n) // R7
      (op == POP_XCHG && wr_en && wr_sel == 3'b000) |=> (regs[IDX_B] == $past(regs[IDX_B])));

   AST_BAD_SEL_DROP: assert property (@(posedge clk) disable iff (!rst_n) // R8
      (pair_op == 3'd0 && wr_en && wr_sel[2:1] == 2'b11) |=> (regs == $past(regs) && sp == $past(sp)));

endmodule

// File: tb/pairreg_file_tb.sv
`timescale 1ns/1ps
module pairreg_file_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  rd_sel_a = '0, rd_sel_b = '0;
   logic [7:0]  rd_data_a, rd_data_b;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [7:0]  wr_data = '0;
   logic [2:0]  pair_op = '0;
   logic [1:0]  pair_sel = '0;
   logic [15:0] pair_imm = '0;
   logic [1:0]  pair_rd_sel = '0;
   logic [15:0] pair_rd_data, hl_addr;

   int checks = 0;
   int fails  = 0;

   // behavioural model
   logic [7:0]  m_r [6];
   logic [15:0] m_sp;

   always #2.5 clk = ~clk;

   pairreg_file u_dut (
      .clk(clk), .rst_n(rst_n),
      .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a),
      .rd_sel_b(rd_sel_b), .rd_data_b(rd_data_b),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pair_op(pair_op), .pair_sel(pair_sel), .pair_imm(pair_imm),
      .pair_rd_sel(pair_rd_sel), .pair_rd_data(pair_rd_data),
      .hl_addr(hl_addr)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] m_byte(input logic [2:0] s);
      return (s < 3'd6) ? m_r[s] : 8'h00;
   endfunction

   function automatic logic [15:0] m_pair(input logic [1:0] s);
      return (s == 2'd3) ? m_sp : {m_r[2*s], m_r[2*s+1]};
   endfunction

   function automatic void m_set_pair(input logic [1:0] s, input logic [15:0] v);
      if (s == 2'd3) m_sp = v;
      else begin
         m_r[2*s]   = v[15:8];
         m_r[2*s+1] = v[7:0];
      end
   endfunction

   function automatic void m_reset();
      for (int i = 0; i < 6; i++) m_r[i] = 8'h00;
      m_sp = 16'h0000;
   endfunction

   // drive one cycle, compare all outputs against the model, then advance
   task automatic cyc(input logic [2:0] op, input logic [1:0] ps, input logic [15:0] imm,
                      input logic we, input logic [2:0] ws, input logic [7:0] wd,
                      input logic [2:0] ra, input logic [2:0] rb, input logic [1:0] pr);
      logic [7:0] d, e;
      @(negedge clk);
      pair_op = op; pair_sel = ps; pair_imm = imm;
      wr_en = we; wr_sel = ws; wr_data = wd;
      rd_sel_a = ra; rd_sel_b = rb; pair_rd_sel = pr;
      #1;
      check("R2 read port A", {8'h00, rd_data_a}, {8'h00, m_byte(ra)});
      check("R2 read port B", {8'h00, rd_data_b}, {8'h00, m_byte(rb)});
      check("R3 pair read", pair_rd_data, m_pair(pr));
      check("R9 hl_addr", hl_addr, m_pair(2'd2));
      @(posedge clk);
      case (op)
         3'd1: m_set_pair(ps, imm);
         3'd2: m_set_pair(ps, m_pair(ps) + 16'd1);
         3'd3: m_set_pair(ps, m_pair(ps) - 16'd1);
         3'd4: begin
            d = m_r[2]; e = m_r[3];
            m_r[2] = m_r[4]; m_r[3] = m_r[5];
            m_r[4] = d; m_r[5] = e;
         end
         default: if (we && ws < 3'd6) m_r[ws] = wd;
      endcase
   endtask

   task automatic idle();
      cyc(3'd0, 2'd0, 16'h0, 1'b0, 3'd0, 8'h0, 3'd0, 3'd1, 2'd0);
   endtask

   task automatic peek_byte(input string tag, input logic [2:0] s, input logic [7:0] exp);
      @(negedge clk);
      pair_op = 3'd0; wr_en = 1'b0; rd_sel_a = s;
      #1;
      check(tag, {8'h00, rd_data_a}, {8'h00, exp});
   endtask

   task automatic peek_pair(input string tag, input logic [1:0] s, input logic [15:0] exp);
      @(negedge clk);
      pair_op = 3'd0; wr_en = 1'b0; pair_rd_sel = s;
      #1;
      check(tag, pair_rd_data, exp);
   endtask

   initial begin
      #(200000 * 5);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R10 reset state
      for (int s = 0; s < 6; s++) peek_byte("R10 byte after reset", 3'(s), 8'h00);
      peek_pair("R10 SP after reset", 2'd3, 16'h0000);

      // R1 byte write
      cyc(3'd0, 2'd0, 16'h0, 1'b1, 3'd0, 8'hA5, 3'd0, 3'd1, 2'd0);
      peek_byte("R1 B written", 3'd0, 8'hA5);
      peek_byte("R1 C untouched", 3'd1, 8'h00);

      // R4/R3 load BC and check byte order
      cyc(3'd1, 2'd0, 16'h1234, 1'b0, 3'd0, 8'h0, 3'd0, 3'd1, 2'd0);
      peek_byte("R3 B high byte", 3'd0, 8'h12);
      peek_byte("R3 C low byte", 3'd1, 8'h34);
      peek_pair("R4 BC loaded", 2'd0, 16'h1234);

      // R5 wrap up on HL, R9 address follows
      cyc(3'd1, 2'd2, 16'hFFFF, 1'b0, 3'd0, 8'h0, 3'd4, 3'd5, 2'd2);
      cyc(3'd2, 2'd2, 16'h0, 1'b0, 3'd0, 8'h0, 3'd4, 3'd5, 2'd2);
      @(negedge clk); pair_op = 3'd0; #1;
      check("R9 hl_addr after wrap", hl_addr, 16'h0000);
      check("R5 HL wrapped up", pair_rd_data, 16'h0000);

      // R5 wrap down on DE, BC unchanged
      cyc(3'd3, 2'd1, 16'h0, 1'b0, 3'd0, 8'h0, 3'd2, 3'd3, 2'd1);
      peek_pair("R5 DE wrapped down", 2'd1, 16'hFFFF);
      peek_pair("R5 BC unchanged", 2'd0, 16'h1234);

      // R6 exchange with a misleading pair_sel
      cyc(3'd1, 2'd1, 16'hBEEF, 1'b0, 3'd0, 8'h0, 3'd0, 3'd1, 2'd1);
      cyc(3'd1, 2'd2, 16'h0102, 1'b0, 3'd0, 8'h0, 3'd0, 3'd1, 2'd2);
      cyc(3'd4, 2'd0, 16'h0, 1'b0, 3'd0, 8'h0, 3'd0, 3'd1, 2'd0);
      peek_pair("R6 HL after swap", 2'd2, 16'hBEEF);
      peek_pair("R6 DE after swap", 2'd1, 16'h0102);
      peek_pair("R6 BC kept", 2'd0, 16'h1234);

      // R7 pair op beats byte write
      cyc(3'd1, 2'd0, 16'h5555, 1'b1, 3'd3, 8'h77, 3'd0, 3'd1, 2'd0);
      peek_pair("R7 BC loaded", 2'd0, 16'h5555);
      peek_byte("R7 E not written", 3'd3, 8'h02);

      // R8 writes to 110 and 111 discarded; R2 they read as zero
      cyc(3'd0, 2'd0, 16'h0, 1'b1, 3'd6, 8'hFF, 3'd6, 3'd7, 2'd0);
      cyc(3'd0, 2'd0, 16'h0, 1'b1, 3'd7, 8'hFF, 3'd6, 3'd7, 2'd0);
      for (int s = 0; s < 6; s++) peek_byte("R8 registers unchanged", 3'(s), m_r[s]);
      peek_byte("R2 select 110 reads zero", 3'd6, 8'h00);
      peek_byte("R2 select 111 reads zero", 3'd7, 8'h00);

      // R4/R5 stack pointer
      cyc(3'd1, 2'd3, 16'hFFFF, 1'b0, 3'd0, 8'h0, 3'd0, 3'd1, 2'd3);
      cyc(3'd2, 2'd3, 16'h0, 1'b0, 3'd0, 8'h0, 3'd0, 3'd1, 2'd3);
      peek_pair("R5 SP wrapped up", 2'd3, 16'h0000);

      // R11 reserved op lets the byte write through
      cyc(3'd5, 2'd0, 16'hAAAA, 1'b1, 3'd5, 8'h3C, 3'd5, 3'd4, 2'd0);
      peek_byte("R11 L written under reserved op", 3'd5, 8'h3C);
      peek_pair("R11 BC unchanged", 2'd0, 16'h5555);

      // random phase, compared every cycle inside cyc
      for (int n = 0; n < 3000; n++) begin
         cyc(3'($urandom_range(0, 7)), 2'($urandom), 16'($urandom),
             1'($urandom), 3'($urandom), 8'($urandom),
             3'($urandom), 3'($urandom), 2'($urandom));
      end

      // R10 asynchronous reset mid-run
      @(negedge clk); rst_n = 1'b0; #1;
      m_reset();
      check("R10 hl_addr in reset", hl_addr, 16'h0000);
      @(negedge clk); rst_n = 1'b1;
      idle();

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule